// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves conditional branches for a 32-bit load/store core with one delay slot. When the decode stage presents a branch, the block evaluates the condition on the two source operands, forms the PC-relative target, and decides whether the return-address register has to be written. Jumps, fetch and the register file are handled elsewhere.

Redirection is deferred. A taken branch is held pending until a single-cycle pulse reports that the instruction following the branch (the delay slot) has been fetched. The redirect pulse, with its target, appears on the next cycle. The link write-back is not held back: it is presented one cycle after the branch is issued, and it is presented whether the branch is taken or not.

Compare-against-zero branches come in two groups. Opcodes 6 and 7 select their condition directly. Opcode 1 is a shared group in which the rt field picks the condition and whether a link is made. An rt value in that group with no defined meaning raises a reserved-instruction flag.

Top module: `bru_unit`

## Requirements
- R1: Opcode 4 is taken when the two operands are equal. Opcode 5 is taken when they differ.
- R2: Opcode 6 is taken when operand A, read as signed, is zero or negative. Opcode 7 is taken when operand A is strictly positive.
- R3: With opcode 1, an rt value of 0 is taken when operand A is negative, and an rt value of 1 is taken when operand A is zero or positive.
- R4: With opcode 1, an rt value of 16 uses the negative condition and an rt value of 17 uses the zero-or-positive condition. Both raise `link_we_o` for exactly one cycle, one cycle after issue, whether the branch is taken or not.
- R5: The link value is the branch's own PC plus 8.
- R6: The branch target is PC + 4 + (sign-extended 16-bit immediate × 4). A negative immediate therefore gives a backward target.
- R7: `redirect_o` stays low until `slot_i` has been seen for a pending taken branch. It rises for one cycle on the clock after that `slot_i` cycle, and `target_o` is valid in that cycle.
- R8: A branch that is not taken never raises `redirect_o`, even after `slot_i`.
- R9: With opcode 1, any rt value other than 0, 1, 16 or 17 raises `rsvd_o` for one cycle, one cycle after issue. It gives neither a link write nor a redirect.
- R10: An issued opcode that is not a branch produces no redirect, no link write and no reserved flag.
- R11: During reset, `redirect_o`, `link_we_o` and `rsvd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | A decoded instruction is presented this cycle |
| opcode_i | input | 6 | Primary opcode field |
| rt_sel_i | input | 5 | rt field, which selects the condition in the opcode-1 group |
| src_a_i | input | 32 | rs operand value |
| src_b_i | input | 32 | rt operand value |
| pc_i | input | 32 | Address of the branch instruction |
| imm_i | input | 16 | Branch offset in words |
| slot_i | input | 1 | Pulse: the delay-slot instruction has been fetched |
| redirect_o | output | 1 | One-cycle pulse: fetch must restart at target_o |
| target_o | output | 32 | Redirect address |
| link_we_o | output | 1 | One-cycle request to write the return-address register |
| link_val_o | output | 32 | Value to write into the return-address register |
| rsvd_o | output | 1 | One-cycle reserved-instruction flag |

## Verification
If the pending flag is corrupted, it shows up at the first `slot_i` pulse: `redirect_o` is either missing or extra on the following cycle. If the decoded condition or the link decision is wrong, `link_we_o` or `rsvd_o` is wrong one cycle after issue. The scoreboard predicts every branch from the operand values. It compares both the issue-side outputs and the slot-side redirect and target on the exact cycle each is due. Idle cycles with no issue and no slot are also checked for spurious pulses.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [5:0] OP_REGIMM = 6'd1;
  localparam logic [5:0] OP_EQ     = 6'd4;
  localparam logic [5:0] OP_NE     = 6'd5;
  localparam logic [5:0] OP_LEZ    = 6'd6;
  localparam logic [5:0] OP_GTZ    = 6'd7;

  localparam logic [4:0] RT_LTZ    = 5'd0;
  localparam logic [4:0] RT_GEZ    = 5'd1;
  localparam logic [4:0] RT_LTZ_LK = 5'd16;
  localparam logic [4:0] RT_GEZ_LK = 5'd17;

  typedef struct packed {
    logic is_br;
    logic taken;
    logic link;
    logic rsvd;
  } br_dec_t;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode_i,
  input  logic [4:0]      rt_sel_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output br_dec_t         dec_o
);
  logic a_neg, a_zero, ab_eq;

  always_comb begin
    a_neg  = src_a_i[XLEN-1];
    a_zero = (src_a_i == '0);
    ab_eq  = (src_a_i == src_b_i);
    dec_o  = '0;
    unique case (opcode_i)
      OP_EQ:  begin dec_o.is_br = 1'b1; dec_o.taken = ab_eq;  end
      OP_NE:  begin dec_o.is_br = 1'b1; dec_o.taken = !ab_eq; end
      OP_LEZ: begin dec_o.is_br = 1'b1; dec_o.taken = a_neg || a_zero; end
      OP_GTZ: begin dec_o.is_br = 1'b1; dec_o.taken = !a_neg && !a_zero; end
      OP_REGIMM: begin
        dec_o.is_br = 1'b1;
        unique case (rt_sel_i)
          RT_LTZ:    dec_o.taken = a_neg;
          RT_GEZ:    dec_o.taken = !a_neg;
          RT_LTZ_LK: begin dec_o.taken = a_neg;  dec_o.link = 1'b1; end
          RT_GEZ_LK: begin dec_o.taken = !a_neg; dec_o.link = 1'b1; end
          default:   dec_o.rsvd = 1'b1;
        endcase
      end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/bru_addr.sv
module bru_addr #(
  parameter int XLEN     = 32,
  parameter int IMMW     = 16,
  parameter int WORD_SH  = 2,
  parameter int LINK_OFS = 8
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o
);
  localparam int EXTW = XLEN - IMMW;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << WORD_SH);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] ofs;

  always_comb begin
    seq_pc   = pc_i + STEP;
    ofs      = {{EXTW{imm_i[IMMW-1]}}, imm_i} << WORD_SH;
    target_o = seq_pc + ofs;
    link_o   = pc_i + XLEN'(LINK_OFS);
  end
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [5:0]      opcode_i,
  input  logic [4:0]      rt_sel_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            slot_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            rsvd_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  br_dec_t         dec;
  logic [XLEN-1:0] tgt_c, link_c;

  bru_cond #(.XLEN(XLEN)) u_cond (
    .opcode_i(opcode_i), .rt_sel_i(rt_sel_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dec_o(dec));

  bru_addr #(.XLEN(XLEN), .IMMW(IMMW)) u_addr (
    .pc_i(pc_i), .imm_i(imm_i), .target_o(tgt_c), .link_o(link_c));

  logic            pend_q, pend_d;
  logic [XLEN-1:0] ptgt_q, ptgt_d;
  logic            redir_q, redir_d;
  logic [XLEN-1:0] otgt_q, otgt_d;
  logic            lwe_q, lwe_d;
  logic [XLEN-1:0] lval_q, lval_d;
  logic            rsvd_q, rsvd_d;
  logic            take_en, fire_en, link_en;

  always_comb begin
    take_en = issue_i && dec.is_br && dec.taken;
    fire_en = slot_i && pend_q;
    link_en = issue_i && dec.link;
    pend_d  = take_en ? 1'b1 : (slot_i ? 1'b0 : pend_q);
    ptgt_d  = take_en ? tgt_c : ptgt_q;
    redir_d = fire_en;
    otgt_d  = fire_en ? ptgt_q : otgt_q;
    lwe_d   = link_en;
    lval_d  = link_en ? link_c : lval_q;
    rsvd_d  = issue_i && dec.rsvd;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_q  <= 1'b0;
      ptgt_q  <= '0;
      redir_q <= 1'b0;
      otgt_q  <= '0;
      lwe_q   <= 1'b0;
      lval_q  <= '0;
      rsvd_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ptgt_q  <= ptgt_d;
      redir_q <= redir_d;
      otgt_q  <= otgt_d;
      lwe_q   <= lwe_d;
      lval_q  <= lval_d;
      rsvd_q  <= rsvd_d;
    end
  end

  assign redirect_o = redir_q;
  assign target_o   = otgt_q;
  assign link_we_o  = lwe_q;
  assign link_val_o = lval_q;
  assign rsvd_o     = rsvd_q;

  // R7: a redirect only follows a delay-slot fetch
  p_redirect_after_slot_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    redirect_o |-> $past(slot_i));
  // R8: a redirect requires an earlier taken branch still pending
  p_redirect_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    redirect_o |-> $past(pend_q));
  // R5: the link value tracks the issuing PC
  p_link_value_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    link_we_o |-> (link_val_o == $past(pc_i) + XLEN'(8)));
  // R9: the reserved flag comes only from the opcode-1 group, and never with a link
  p_rsvd_source_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsvd_o |-> ($past(issue_i) && $past(opcode_i) == OP_REGIMM && !link_we_o));
  // R4: a link request is a single-cycle pulse after an issue
  p_link_after_issue_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    link_we_o |-> $past(issue_i));
endmodule

// File: tb/bru_unit_test.sv
module bru_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i, slot_i;
  logic [5:0]  opcode_i;
  logic [4:0]  rt_sel_i;
  logic [31:0] src_a_i, src_b_i, pc_i;
  logic [15:0] imm_i;
  logic        redirect_o, link_we_o, rsvd_o;
  logic [31:0] target_o, link_val_o;

  always #5 clk = ~clk;

  bru_unit uut (.*);

  typedef struct {
    string       req;
    logic        taken;
    logic        lwe;
    logic        rsv;
    logic [31:0] tgt;
    logic [31:0] lval;
  } exp_t;

  exp_t exp_q[$];
  int   nchk = 0, nerr = 0;
  logic mon_en = 1'b0;
  logic iss_d = 1'b0, slot_d = 1'b0;
  logic m_pend = 1'b0;
  logic [31:0] m_tgt = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    iss_d  <= issue_i;
    slot_d <= slot_i;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (slot_d) begin
        chk(m_pend ? "R7" : "R8", {31'd0, redirect_o}, {31'd0, m_pend});
        if (m_pend) chk("R6", target_o, m_tgt);
        m_pend = 1'b0;
      end else begin
        chk("R7", {31'd0, redirect_o}, 32'd0);
      end
      if (iss_d && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, {31'd0, link_we_o}, {31'd0, e.lwe});
        chk(e.req, {31'd0, rsvd_o}, {31'd0, e.rsv});
        if (e.lwe) chk("R5", link_val_o, e.lval);
        if (e.taken) begin m_pend = 1'b1; m_tgt = e.tgt; end
      end else begin
        chk("R4", {31'd0, link_we_o}, 32'd0);
        chk("R9", {31'd0, rsvd_o}, 32'd0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic br(input string req, input logic [5:0] op, input logic [4:0] rt,
                    input logic [31:0] a, input logic [31:0] b,
                    input logic [31:0] pc, input logic [15:0] imm);
    exp_t e;
    logic sa_neg, sa_zero;
    sa_neg  = a[31];
    sa_zero = (a == 0);
    e.req = req; e.taken = 0; e.lwe = 0; e.rsv = 0;
    e.tgt  = pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    e.lval = pc + 32'd8;
    case (op)
      6'd4: e.taken = (a == b);
      6'd5: e.taken = (a != b);
      6'd6: e.taken = sa_neg || sa_zero;
      6'd7: e.taken = !sa_neg && !sa_zero;
      6'd1: begin
        if (rt == 5'd0 || rt == 5'd16) e.taken = sa_neg;
        else if (rt == 5'd1 || rt == 5'd17) e.taken = !sa_neg;
        else e.rsv = 1;
        e.lwe = (rt == 5'd16 || rt == 5'd17);
      end
      default: ;
    endcase
    @(negedge clk);
    issue_i = 1; opcode_i = op; rt_sel_i = rt; src_a_i = a; src_b_i = b;
    pc_i = pc; imm_i = imm;
    exp_q.push_back(e);
    @(negedge clk);
    issue_i = 0;
  endtask

  task automatic slot();
    slot_i = 1;
    @(negedge clk);
    slot_i = 0;
  endtask

  task automatic br_slot(input string req, input logic [5:0] op, input logic [4:0] rt,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] pc, input logic [15:0] imm);
    br(req, op, rt, a, b, pc, imm);
    idle(1);
    slot();
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; issue_i = 0; slot_i = 0; opcode_i = 0; rt_sel_i = 0;
    src_a_i = 0; src_b_i = 0; pc_i = 0; imm_i = 0;
    idle(3);
    chk("R11", {29'd0, redirect_o, link_we_o, rsvd_o}, 32'd0);
    rst_n = 1;
    idle(4);
    mon_en = 1;

    br_slot("R1", 6'd4, 5'd0, 32'd7, 32'd7, 32'h20, 16'd3);
    br_slot("R1", 6'd4, 5'd0, 32'd7, 32'd8, 32'h20, 16'd3);
    br_slot("R1", 6'd5, 5'd0, 32'd1, 32'd2, 32'h100, 16'd10);
    br_slot("R1", 6'd5, 5'd0, 32'd9, 32'd9, 32'h100, 16'd10);
    br_slot("R2", 6'd6, 5'd0, 32'd0, 32'd0, 32'h40, 16'd5);
    br_slot("R2", 6'd6, 5'd0, 32'hFFFF_FFFF, 32'd0, 32'h40, 16'd5);
    br_slot("R2", 6'd6, 5'd0, 32'd4, 32'd0, 32'h40, 16'd5);
    br_slot("R2", 6'd7, 5'd0, 32'd4, 32'd0, 32'h80, 16'd2);
    br_slot("R2", 6'd7, 5'd0, 32'd0, 32'd0, 32'h80, 16'd2);
    br_slot("R2", 6'd7, 5'h0, 32'h8000_0000, 32'd0, 32'h80, 16'd2);
    br_slot("R3", 6'd1, 5'd0, 32'hFFFF_FFFF, 32'd0, 32'h200, 16'd1);
    br_slot("R3", 6'd1, 5'd0, 32'd0, 32'd0, 32'h200, 16'd1);
    br_slot("R3", 6'd1, 5'd1, 32'd0, 32'd0, 32'h200, 16'd1);
    br_slot("R3", 6'd1, 5'd1, 32'h8000_0000, 32'd0, 32'h200, 16'd1);
    br_slot("R4", 6'd1, 5'd16, 32'hFFFF_FFF0, 32'd0, 32'h300, 16'd4);
    br_slot("R4", 6'd1, 5'd16, 32'd5, 32'd0, 32'h304, 16'd4);
    br_slot("R4", 6'd1, 5'd17, 32'd5, 32'd0, 32'h308, 16'd4);
    br_slot("R4", 6'd1, 5'd17, 32'hFFFF_FFFF, 32'd0, 32'h30C, 16'd4);
    br_slot("R6", 6'd4, 5'd0, 32'd1, 32'd1, 32'h1000, 16'hFFFC);
    br_slot("R6", 6'd5, 5'd0, 32'd1, 32'd2, 32'h1000, 16'h8000);
    br_slot("R9", 6'd1, 5'd5, 32'hFFFF_FFFF, 32'd0, 32'h400, 16'd3);
    br_slot("R9", 6'd1, 5'd18, 32'd0, 32'd0, 32'h400, 16'd3);
    br_slot("R10", 6'd8, 5'd16, 32'd0, 32'd0, 32'h500, 16'd3);
    br_slot("R10", 6'd0, 5'd1, 32'd3, 32'd3, 32'h500, 16'd3);

    // R7: a taken branch waits several cycles for the delay-slot fetch
    br("R7", 6'd4, 5'd0, 32'd3, 32'd3, 32'h600, 16'd7);
    idle(5);
    slot();
    idle(2);
    // R8: a slot pulse with nothing pending
    slot();
    idle(2);
    // R7: a new branch issued in the same cycle as the slot of the previous one
    br("R7", 6'd5, 5'd0, 32'd1, 32'd0, 32'h700, 16'd1);
    @(negedge clk);
    issue_i = 1; opcode_i = 6'd7; rt_sel_i = 0; src_a_i = 32'd2; src_b_i = 0;
    pc_i = 32'h800; imm_i = 16'd2; slot_i = 1;
    begin
      exp_t e;
      e.req = "R7"; e.taken = 1; e.lwe = 0; e.rsv = 0;
      e.tgt = 32'h80C; e.lval = 32'h808;
      exp_q.push_back(e);
    end
    @(negedge clk);
    issue_i = 0; slot_i = 0;
    idle(1);
    slot();
    idle(3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule